// File: doc/BRIEF.md
# VID Reference Ramp Sequencer

The sequencer moves an internal reference code toward a target voltage-identification (VID) code one code at a time. It does not jump. It advances only when the PWM-cycle tick strobe is high, so the reference slews at a rate set by the switching frequency. The time to reach a target is therefore the code distance in ticks, plus a fixed pause whenever the ramp has to turn around. All values are plain integer codes, and a larger code means a higher voltage.

The VID input may change at any cycle, including mid-ramp. The block judges each new code against the reference value it holds at that moment, not against the target it was last heading for. Three outcomes are possible:
- If the new code lies further along the present direction of travel, stepping carries on without a gap.
- If reaching the new code needs the opposite direction, stepping stops and the block waits for two ticks, then ramps the other way.
- If the new code equals the present reference, the ramp ends at once.

The control is a three-state machine:
- `ST_IDLE`: the code equals the target.
- `ST_RAMP`: the block steps on each tick.
- `ST_HOLD`: the block counts out the reversal pause.

The named transitions are:
- START (idle to ramp, on a new code).
- LAND (ramp to idle, when a step reaches the target).
- ARRIVE (ramp or hold to idle, when the new code equals the present reference).
- REVERSE (ramp to hold, when the new code needs the opposite direction).
- RESUME (hold to ramp, on the second pause tick).
- RETARGET (hold stays in hold, on a new code).

Top module: `vid_ramp_seq`

## Requirements
- R1: While `rst_n` is low on a clock edge, `dac_code` and the latched target take the value on `vid`, with no ramp. After reset, `busy` is 0 and `at_target` is 1.
- R2: `dac_code` only ever changes by exactly one code. It changes only on a clock edge where `tick` was 1.
- R3: From idle, a new `vid` code starts a ramp. On each ticked edge, `dac_code` moves one code toward `vid`. It arrives after as many ticks as the code distance, and a tick on the same edge as the change already counts as a step.
- R4: A new `vid` code that arrives mid-ramp and lies beyond the present `dac_code` in the direction of travel leaves stepping uninterrupted. A tick on that same edge still steps.
- R5: A new `vid` code that arrives mid-ramp and needs the opposite direction stops stepping. The next two ticks produce no step, and the third tick steps toward the new code.
- R6: The direction test compares the new code with the present `dac_code`, not with the old target. For example, when ramping up from 25 toward 30 with `dac_code` at 27, a new code of 28 continues upward with no pause.
- R7: A new `vid` code equal to the present `dac_code` ends the transition on that edge, during a ramp or a pause. No step and no wait follow.
- R8: `busy` is 1 in ramp and hold and 0 in idle. `at_target` is 1 only when `dac_code` equals the latched target and no pause is pending.
- R9: With no ticks, `dac_code` holds its value even while `vid` differs from it.
- R10: A new `vid` code during the pause that does not equal `dac_code` leaves the pause count running. Stepping then resumes toward the newest code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads `vid` into the reference |
| tick | input | 1 | One-cycle strobe, once per PWM cycle |
| vid | input | CODE_W | Target code; higher means higher voltage |
| dac_code | output | CODE_W | Present reference code |
| busy | output | 1 | Transition or pause in progress |
| at_target | output | 1 | Reference equals target and no pause is pending |

## Verification
Every output is registered. A `vid` or `tick` value present before edge k shows its effect on `dac_code`, `busy` and `at_target` right after edge k. After a reversal, the first step appears after the third ticked edge. The bench drives inputs at the falling edge and compares all three outputs with a behavioural model at the next falling edge, every cycle. It also checks fixed values after edges counted by hand: arrival after the code distance in ticks, the two frozen ticks after a turn-around, and the immediate return to idle when the new code equals the present reference.

// File: rtl/vid_ramp_pkg.sv
package vid_ramp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAMP = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        JD_NONE     = 3'd0,
        JD_ARRIVE   = 3'd1,
        JD_START    = 3'd2,
        JD_FOLLOW   = 3'd3,
        JD_REVERSE  = 3'd4,
        JD_RETARGET = 3'd5
    } verdict_e;

endpackage

// File: rtl/vid_ramp_judge.sv
module vid_ramp_judge
    import vid_ramp_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] vid,
    input  logic [CODE_W-1:0] dac,
    input  logic [CODE_W-1:0] target,
    input  seq_state_e        state,
    input  logic              dir_up,
    output verdict_e          verdict,
    output logic              want_up
);

    always_comb begin
        want_up = (vid > dac);
        verdict = JD_NONE;
        if (vid != target) begin
            if (vid == dac) begin
                verdict = JD_ARRIVE;
            end else begin
                unique case (state)
                    ST_IDLE: verdict = JD_START;
                    ST_RAMP: verdict = (want_up == dir_up) ? JD_FOLLOW : JD_REVERSE;
                    ST_HOLD: verdict = JD_RETARGET;
                    default: verdict = JD_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/vid_ramp_hold_cnt.sv
module vid_ramp_hold_cnt #(
    parameter int WAIT_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic adv,
    output logic done
);

    localparam int CW = $clog2(WAIT_TICKS + 1);

    logic [CW-1:0] cnt_q;

    assign done = adv && (cnt_q == CW'(WAIT_TICKS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= done ? '0 : cnt_q + CW'(1);
        end
    end

    // R5: the pause counter never runs past the programmed wait
    p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(WAIT_TICKS));

endmodule

// File: rtl/vid_ramp_dac.sv
module vid_ramp_dac #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] load_val,
    input  logic              step,
    input  logic              up,
    output logic [CODE_W-1:0] dac
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac <= load_val;
        end else if (step) begin
            dac <= up ? dac + CODE_W'(1) : dac - CODE_W'(1);
        end
    end

endmodule

// File: rtl/vid_ramp_seq.sv
module vid_ramp_seq
    import vid_ramp_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int WAIT_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] vid,
    output logic [CODE_W-1:0] dac_code,
    output logic              busy,
    output logic              at_target
);

    seq_state_e        state_q, state_d;
    logic [CODE_W-1:0] target_q;
    logic              dir_q, dir_d;
    logic              live_q;
    verdict_e          verdict;
    logic              want_up;
    logic              step_en;
    logic              hold_clr, hold_adv, hold_done;
    logic              near;
    logic [CODE_W-1:0] dac_up1, dac_dn1;

    vid_ramp_judge #(.CODE_W(CODE_W)) u_judge (
        .vid     (vid),
        .dac     (dac_code),
        .target  (target_q),
        .state   (state_q),
        .dir_up  (dir_q),
        .verdict (verdict),
        .want_up (want_up)
    );

    vid_ramp_hold_cnt #(.WAIT_TICKS(WAIT_TICKS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hold_clr),
        .adv   (hold_adv),
        .done  (hold_done)
    );

    vid_ramp_dac #(.CODE_W(CODE_W)) u_dac (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (vid),
        .step     (step_en),
        .up       (want_up),
        .dac      (dac_code)
    );

    assign dac_up1 = dac_code + CODE_W'(1);
    assign dac_dn1 = dac_code - CODE_W'(1);
    assign near    = want_up ? (dac_up1 == vid) : (dac_dn1 == vid);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            target_q <= vid;
            dir_q    <= 1'b1;
            live_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            target_q <= vid;
            dir_q    <= dir_d;
            live_q   <= 1'b1;
        end
    end

    // next state and step control
    always_comb begin
        state_d  = state_q;
        dir_d    = dir_q;
        step_en  = 1'b0;
        hold_clr = 1'b0;
        hold_adv = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (verdict == JD_START) begin          // START
                    state_d = ST_RAMP;
                    dir_d   = want_up;
                    if (tick) begin
                        step_en = 1'b1;
                        if (near) state_d = ST_IDLE;   // LAND
                    end
                end
            end
            ST_RAMP: begin
                if (verdict == JD_ARRIVE) begin         // ARRIVE
                    state_d = ST_IDLE;
                end else if (verdict == JD_REVERSE) begin // REVERSE
                    state_d  = ST_HOLD;
                    dir_d    = want_up;
                    hold_clr = 1'b1;
                end else if (tick) begin
                    step_en = 1'b1;
                    if (near) state_d = ST_IDLE;       // LAND
                end
            end
            ST_HOLD: begin
                if (verdict == JD_ARRIVE) begin         // ARRIVE
                    state_d  = ST_IDLE;
                    hold_clr = 1'b1;
                end else begin
                    if (verdict == JD_RETARGET) dir_d = want_up; // RETARGET
                    hold_adv = tick;
                    if (hold_done) state_d = ST_RAMP;  // RESUME
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        at_target = (dac_code == target_q) && (state_q != ST_HOLD);
    end

    // R2: single-code moves only
    p_one_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && dac_code != $past(dac_code)) |->
        (dac_code == $past(dac_code) + CODE_W'(1) || dac_code == $past(dac_code) - CODE_W'(1)));

    // R2: moves only after a ticked edge
    p_step_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && dac_code != $past(dac_code)) |-> $past(tick));

    // R5: reversal mid-ramp enters the pause
    p_reverse_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && verdict == JD_REVERSE) |=> (state_q == ST_HOLD));

    // R5: no step leaves the pause state
    p_hold_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(dac_code));

    // R7: new code equal to the reference ends at once
    p_arrive_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == JD_ARRIVE) |=> (state_q == ST_IDLE && at_target));

    // R8: idle implies the reference sits on the target
    p_idle_on_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (dac_code == target_q));

endmodule

// File: tb/vid_ramp_seq_bench.sv
module vid_ramp_seq_bench;

    localparam int CODE_W = 6;
    localparam int MAXC   = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [CODE_W-1:0] vid = '0;
    logic [CODE_W-1:0] dac_code;
    logic              busy, at_target;

    int    n_checks = 0;
    int    n_errors = 0;
    int    n_cycles = 0;
    string phase = "R1";

    // behavioural reference
    int m_dac = 0, m_tgt = 0, m_mode = 0, m_wait = 0;
    bit m_up = 1'b1;

    always #10 clk = ~clk;

    vid_ramp_seq #(.CODE_W(CODE_W), .WAIT_TICKS(2)) u_vid_ramp_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .vid       (vid),
        .dac_code  (dac_code),
        .busy      (busy),
        .at_target (at_target)
    );

    always @(posedge clk) begin
        int v;
        bit nv;
        v = int'(vid);
        if (!rst_n) begin
            m_dac = v; m_tgt = v; m_mode = 0; m_wait = 0; m_up = 1'b1;
        end else begin
            nv = (v != m_tgt);
            m_tgt = v;
            if (nv && v == m_dac) begin
                m_mode = 0;
            end else if (m_mode == 0) begin
                if (nv) begin
                    m_mode = 1; m_up = (v > m_dac);
                    if (tick) begin
                        m_dac = m_up ? m_dac + 1 : m_dac - 1;
                        if (m_dac == v) m_mode = 0;
                    end
                end
            end else if (m_mode == 1) begin
                if (nv && ((v > m_dac) != m_up)) begin
                    m_mode = 2; m_up = (v > m_dac); m_wait = 0;
                end else if (tick) begin
                    m_dac = m_up ? m_dac + 1 : m_dac - 1;
                    if (m_dac == v) m_mode = 0;
                end
            end else begin
                if (nv) m_up = (v > m_dac);
                if (tick) begin
                    m_wait++;
                    if (m_wait == 2) begin m_mode = 1; m_wait = 0; end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk(int'(dac_code) == m_dac, {phase, " dac_code vs model"}, int'(dac_code), m_dac);
        chk(busy == (m_mode != 0), {phase, " busy vs model"}, int'(busy), int'(m_mode != 0));
        chk(at_target == (m_dac == m_tgt && m_mode != 2), {phase, " at_target vs model"},
            int'(at_target), int'(m_dac == m_tgt && m_mode != 2));
    endtask

    // drive at falling edge, apply one rising edge, compare at next falling edge
    task automatic cyc(input bit t, input int v);
        tick = t;
        vid  = CODE_W'(v);
        @(posedge clk);
        @(negedge clk);
        n_cycles++;
        cmp_model();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        vid = CODE_W'(20);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_model();
        chk(int'(dac_code) == 20, "R1 reset loads vid", int'(dac_code), 20);
        chk(!busy && at_target, "R1 idle after reset", int'({busy, at_target}), 1);

        phase = "R3";
        repeat (4) cyc(1, 25);
        chk(int'(dac_code) == 24 && busy, "R3 mid ramp", int'(dac_code), 24);
        cyc(1, 25);
        chk(int'(dac_code) == 25 && !busy && at_target, "R3 landed after 5 ticks", int'(dac_code), 25);

        phase = "R9";
        repeat (3) cyc(0, 30);
        chk(int'(dac_code) == 25 && busy && !at_target, "R9 no tick no move", int'(dac_code), 25);

        phase = "R6";
        repeat (2) cyc(1, 30);
        cyc(1, 28);
        chk(int'(dac_code) == 28 && !busy, "R6 judged vs dac, continues", int'(dac_code), 28);

        phase = "R4";
        repeat (2) cyc(1, 35);
        cyc(1, 40);
        chk(int'(dac_code) == 31 && busy, "R4 no pause on same direction", int'(dac_code), 31);

        phase = "R5";
        cyc(1, 20);
        chk(int'(dac_code) == 31 && busy && !at_target, "R5 halt on reversal", int'(dac_code), 31);
        cyc(1, 20);
        chk(int'(dac_code) == 31, "R5 first wait tick", int'(dac_code), 31);
        cyc(1, 20);
        chk(int'(dac_code) == 31, "R5 second wait tick", int'(dac_code), 31);
        cyc(1, 20);
        chk(int'(dac_code) == 30, "R5 resume on third tick", int'(dac_code), 30);

        phase = "R10";
        cyc(1, 33);
        chk(int'(dac_code) == 30 && busy && !at_target, "R8 pause busy, not at target", int'(dac_code), 30);
        cyc(1, 36);
        cyc(1, 36);
        chk(int'(dac_code) == 30, "R10 count kept over retarget", int'(dac_code), 30);
        cyc(1, 36);
        chk(int'(dac_code) == 31, "R10 resumes toward newest code", int'(dac_code), 31);

        phase = "R7";
        cyc(0, 31);
        chk(!busy && at_target && int'(dac_code) == 31, "R7 equal code ends ramp", int'(dac_code), 31);
        cyc(1, 35);
        cyc(1, 20);
        cyc(0, 32);
        chk(!busy && at_target && int'(dac_code) == 32, "R7 equal code ends pause", int'(dac_code), 32);

        phase = "R2/R4/R5/R6/R8";
        for (int i = 0; i < 4000; i++) begin
            int v;
            v = int'(vid);
            if ($urandom_range(0, 5) == 0) begin
                v = m_dac + $urandom_range(0, 12) - 6;
                if (v < 0) v = 0;
                if (v > MAXC) v = MAXC;
            end
            cyc(bit'($urandom_range(0, 1)), v);
        end

        finish_run();
    end

endmodule